// File: doc/BRIEF.md
# Stream-to-Memory DMA Channel with Retire-Gated Completion

This block moves a unit of data elements from a peripheral stream into memory. Elements arrive on a valid/ready input. Each accepted element is paired with its destination address and placed in a small local queue. The queue drains into a posted memory write port. That port may hold several writes in flight and acknowledges them in order, each after a latency the memory chooses.

Software sets a destination address, an element count and an element size (8, 16 or 32 bits), then writes the start bit. The current-address and remaining-count registers advance as soon as an element enters the queue, so they can run ahead of memory by a bounded amount. This bound is the queue capacity plus the number of writes allowed in flight. Completion works differently. The done status bit and the interrupt rise only once the queue is empty and every issued write has been acknowledged, which means the whole unit is committed when software sees them.

A build parameter switches the queue between eight locations (memory-to-memory use) and four locations (peripheral use). A 32-bit element takes two locations, so the element capacity is halved for that size.

Top module: `dma_defer_chan`

## Requirements
- R1: After reset the channel is idle: status reads 0, `irqOut`, `inReady` and `memReq` are low.
- R2: Writing 1 to bit 0 of register 0 while idle loads the current address and remaining count from the programmed start address (register 1) and element count (register 2). It also sets the running bit (status bit 0) and clears the done bit (status bit 1). A read of register 1 or 2 returns the current address or the remaining count.
- R3: Each element accepted on the stream decrements the remaining count by one and advances the current address by 1, 2 or 4 bytes. The step is set by the size code written to register 3 bits [1:0]: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R4: The queue holds at most 4 elements of 8 or 16 bits, or 2 elements of 32 bits (8 and 4 in memory-to-memory builds). While it is full, `inReady` is low and the current address and count do not change.
- R5: No more than `MAX_OUT` (default 6) memory writes are outstanding (issued but not yet acknowledged).
- R6: Writes are issued in stream order. Each carries its element's address, its full 32-bit element data, and the unit's size code on `memSize`.
- R7: Done and `irqOut` rise only after the last write of the unit has been acknowledged. At that moment every element of the unit is committed in memory.
- R8: At every cycle, elements counted off minus writes acknowledged never exceeds the element capacity of the queue plus `MAX_OUT`.
- R9: `irqOut` follows the done bit. Writing 1 to bit 1 of register 0 clears done; writing 0 there leaves it set.
- R10: A start write while the channel is running changes neither the current address nor the count.
- R11: A unit with an element count of zero completes (done set, running cleared) without any memory write.
- R12: Register 3 reads back the programmed size code in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control/status, 1 address, 2 count, 3 size |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| inValid | input | 1 | Stream element valid |
| inData | input | 32 | Stream element data |
| inReady | output | 1 | Channel can accept an element |
| memReq | output | 1 | Posted write issue, one write per cycle high |
| memAddr | output | 32 | Byte address of the issued write |
| memData | output | 32 | Data of the issued write |
| memSize | output | 2 | Size code of the issued write |
| memAck | input | 1 | One pulse per retired write, in issue order |
| irqOut | output | 1 | Completion interrupt |

## Verification
The bench stalls the memory completely with an always-valid stream. This shows whether the stall point of the count and address registers matches the queue capacity for each element size, kept separate from the in-flight limit. Bursty random streams combined with random acknowledge latency then move the lead of the counters over memory around within its bound. These runs also expose a completion raised on issue rather than on retirement, because the bench memory contents are compared at the interrupt edge. Directed cases cover a zero-length unit, a start written mid-run, and clearing the done bit by writing one versus writing zero.

// File: rtl/dma_defer_pkg.sv
package dma_defer_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elemSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              push;
    logic [ADDR_W-1:0] pushAddr;
    elemSize_e         size;
  } dpStrobe_t;

  function automatic logic [2:0] stepOf(elemSize_e s);
    case (s)
      SZ_BYTE: stepOf = 3'd1;
      SZ_HALF: stepOf = 3'd2;
      default: stepOf = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_defer_dp.sv
module dma_defer_dp
  import dma_defer_pkg::*;
#(
  parameter int LOCS    = 4,
  parameter int MAX_OUT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] inData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [1:0]        memSize,
  input  logic              memAck,
  output logic              dpRoom,
  output logic              dpIdle
);
  localparam int PW = (LOCS > 1) ? $clog2(LOCS) : 1;
  localparam int CW = $clog2(LOCS + 1);
  localparam int OW = $clog2(MAX_OUT + 1);

  logic [ADDR_W-1:0] addrQ [LOCS];
  logic [DATA_W-1:0] dataQ [LOCS];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     fill, cap;
  logic [OW-1:0]     outst;
  logic              pop;

  // 32-bit elements use two locations each
  assign cap    = (strb.size inside {SZ_BYTE, SZ_HALF}) ? CW'(LOCS) : CW'(LOCS / 2);
  assign pop    = (fill != '0) && (outst < OW'(MAX_OUT));
  assign dpRoom = fill < cap;
  assign dpIdle = (fill == '0) && (outst == '0);

  assign memReq  = pop;
  assign memAddr = addrQ[rdPtr];
  assign memData = dataQ[rdPtr];
  assign memSize = strb.size;

  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrQ[wrPtr] <= strb.pushAddr;
      dataQ[wrPtr] <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
      outst <= '0;
    end else begin
      if (strb.load) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strb.push) wrPtr <= (wrPtr == PW'(LOCS - 1)) ? '0 : wrPtr + 1'b1;
        if (pop)       rdPtr <= (rdPtr == PW'(LOCS - 1)) ? '0 : rdPtr + 1'b1;
      end
      fill  <= fill + CW'(strb.push) - CW'(pop);
      outst <= outst + OW'(pop) - OW'(memAck);
    end
  end

  // control must never push into a full queue
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> fill < cap);
  // memory may only retire a write that was issued
  p_ack_matches_issue_r5: assert property (@(posedge clk) disable iff (!rstN)
    memAck |-> outst != '0);
  // in-flight count stays within its limit
  p_inflight_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    outst == OW'(MAX_OUT) && !memAck |=> !memReq || $past(memAck));
  // idle datapath issues nothing
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    dpIdle |-> !memReq);
endmodule

// File: rtl/dma_defer_ctrl.sv
module dma_defer_ctrl
  import dma_defer_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              inValid,
  output logic              inReady,
  output dpStrobe_t         strb,
  input  logic              dpRoom,
  input  logic              dpIdle,
  output logic              irqOut
);
  logic [ADDR_W-1:0]  progAddr, curAddr;
  logic [COUNT_W-1:0] progCount, curCount;
  elemSize_e          progSize, unitSize;
  logic               running, done;
  logic               startReq, clrReq, startTake, push, finish;

  assign startReq  = regWr && (regAddr == 2'd0) && regWdata[0];
  assign clrReq    = regWr && (regAddr == 2'd0) && regWdata[1];
  assign startTake = startReq && !running;
  assign inReady   = running && (curCount != '0) && dpRoom;
  assign push      = inValid && inReady;
  assign finish    = running && (curCount == '0) && dpIdle;
  assign irqOut    = done;

  assign strb.load     = startTake;
  assign strb.push     = push;
  assign strb.pushAddr = curAddr;
  assign strb.size     = unitSize;

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = {30'b0, done, running};
      2'd1:    regRdata = curAddr;
      2'd2:    regRdata = 32'(curCount);
      default: regRdata = {30'b0, progSize};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr  <= '0;
      progCount <= '0;
      progSize  <= SZ_BYTE;
    end else if (regWr) begin
      case (regAddr)
        2'd1:    progAddr  <= regWdata;
        2'd2:    progCount <= regWdata[COUNT_W-1:0];
        2'd3:    progSize  <= elemSize_e'(regWdata[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curCount <= '0;
      unitSize <= SZ_BYTE;
      running  <= 1'b0;
      done     <= 1'b0;
    end else if (startTake) begin
      curAddr  <= progAddr;
      curCount <= progCount;
      unitSize <= progSize;
      running  <= 1'b1;
      done     <= 1'b0;
    end else begin
      if (push) begin
        curAddr  <= curAddr + ADDR_W'(stepOf(unitSize));
        curCount <= curCount - 1'b1;
      end
      if (finish) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else if (clrReq) begin
        done <= 1'b0;
      end
    end
  end

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    push |=> curCount == $past(curCount) - 1'b1);
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    running && !push |=> $stable(curCount) && $stable(curAddr));
  p_done_after_retire_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(dpIdle));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    running && startReq && !push |=> $stable(curAddr) && $stable(curCount));
endmodule

// File: rtl/dma_defer_chan.sv
module dma_defer_chan
  import dma_defer_pkg::*;
#(
  parameter bit MEM2MEM = 1'b0,
  parameter int MAX_OUT = 6,
  parameter int COUNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        inValid,
  input  logic [31:0] inData,
  output logic        inReady,
  output logic        memReq,
  output logic [31:0] memAddr,
  output logic [31:0] memData,
  output logic [1:0]  memSize,
  input  logic        memAck,
  output logic        irqOut
);
  localparam int LOCS = MEM2MEM ? 8 : 4;

  dpStrobe_t strb;
  logic      dpRoom, dpIdle;

  dma_defer_ctrl #(.COUNT_W(COUNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inValid(inValid),
    .inReady(inReady), .strb(strb), .dpRoom(dpRoom), .dpIdle(dpIdle),
    .irqOut(irqOut)
  );

  dma_defer_dp #(.LOCS(LOCS), .MAX_OUT(MAX_OUT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memSize(memSize), .memAck(memAck), .dpRoom(dpRoom), .dpIdle(dpIdle)
  );
endmodule

// File: tb/dma_defer_chan_tb_top.sv
`timescale 1ns/1ps
module dma_defer_chan_tb_top;
  localparam int MAXOUT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady, memReq, memAck = 1'b0, irqOut;
  logic [31:0] memAddr, memData;
  logic [1:0]  memSize;

  dma_defer_chan dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inValid(inValid),
    .inData(inData), .inReady(inReady), .memReq(memReq),
    .memAddr(memAddr), .memData(memData), .memSize(memSize),
    .memAck(memAck), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  logic [31:0] stream [64];
  logic [7:0]  bmem [1024];
  int acceptIdx = 0, reqCount = 0, ackCount = 0;
  bit willAccept = 0, streamOn = 0, memStall = 0, irqPrev = 0, irqSeen = 0;
  int streamPct = 100, expBase = 0, expN = 0, expSize = 0;
  logic [31:0] pAddr [16], pData [16];
  int pTime [16], pSz [16];
  int pHead = 0, pCnt = 0;
  logic [31:0] cAddr = '0, cData = '0;
  int cSz = 0;

  function automatic int stepOf(int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction
  function automatic int capOf(int s);
    return (s >= 2) ? 2 : 4;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit unitCommitted();
    for (int k = 0; k < expN; k++)
      for (int b = 0; b < stepOf(expSize); b++)
        if (bmem[(expBase + k * stepOf(expSize) + b) & 1023] != stream[k][8*b +: 8])
          return 1'b0;
    return 1'b1;
  endfunction

  // stream source, behavioural memory and per-cycle bound checks
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
    if (willAccept) acceptIdx++;
    if (memAck) begin
      for (int b = 0; b < stepOf(cSz); b++) bmem[(cAddr + b) & 1023] = cData[8*b +: 8];
      ackCount++;
    end
    memAck = 1'b0;
    if (rstN) begin
      if (acceptIdx - ackCount > capOf(expSize) + MAXOUT)
        check(0, "R8", "lag bound", acceptIdx - ackCount, capOf(expSize) + MAXOUT);
      if (reqCount - ackCount > MAXOUT)
        check(0, "R5", "in-flight writes", reqCount - ackCount, MAXOUT);
    end
    if (irqOut && !irqPrev) begin
      irqSeen = 1;
      check(ackCount == expN, "R7", "acks at irq rise", ackCount, expN);
      check(unitCommitted(), "R7", "data committed at irq rise", 0, 1);
    end
    irqPrev = irqOut;
    if (!memStall && pCnt > 0 && pTime[pHead] == 0) begin
      memAck = 1'b1;
      cAddr = pAddr[pHead]; cData = pData[pHead]; cSz = pSz[pHead];
      pHead = (pHead + 1) % 16; pCnt--;
    end
    for (int k = 0; k < pCnt; k++)
      if (pTime[(pHead + k) % 16] > 0) pTime[(pHead + k) % 16]--;
    if (memReq) begin
      if (memAddr != 32'(expBase + reqCount * stepOf(expSize)) ||
          memData != stream[reqCount & 63] || int'(memSize) != expSize)
        check(0, "R6", "write address", memAddr, expBase + reqCount * stepOf(expSize));
      pAddr[(pHead + pCnt) % 16] = memAddr;
      pData[(pHead + pCnt) % 16] = memData;
      pSz[(pHead + pCnt) % 16]   = int'(memSize);
      pTime[(pHead + pCnt) % 16] = int'($urandom % 4);
      pCnt++;
      reqCount++;
    end
    inValid = streamOn && (acceptIdx < 64) && (int'($urandom % 100) < streamPct);
    inData  = stream[acceptIdx & 63];
    willAccept = inValid && inReady;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a; #0.5;
    d = regRdata;
  endtask

  task automatic setup(int base, int n, int sz, int pct, bit stall);
    @(negedge clk); #1;
    streamOn = 0; memStall = stall; streamPct = pct;
    expBase = base; expN = n; expSize = sz;
    acceptIdx = 0; reqCount = 0; ackCount = 0; irqSeen = 0;
    for (int k = 0; k < 64; k++) stream[k] = $urandom;
    for (int k = 0; k < 1024; k++) bmem[k] = 8'h00;
    wr(2'd1, 32'(base));
    wr(2'd2, 32'(n));
    wr(2'd3, 32'(sz));
  endtask

  task automatic waitIrq(string req);
    int t;
    t = 0;
    while (!irqSeen && t < 5000) begin @(negedge clk); t++; end
    check(irqSeen, req, "irq within timeout", irqSeen, 1);
  endtask

  task automatic runUnit(int base, int n, int sz, int pct);
    logic [31:0] v;
    setup(base, n, sz, pct, 0);
    wr(2'd0, 32'h1);
    @(negedge clk); #1; streamOn = 1;
    waitIrq("R7");
    rd(2'd1, v); check(v == 32'(base + n * stepOf(sz)), "R3", "final address", v, base + n * stepOf(sz));
    rd(2'd2, v); check(v == 0, "R3", "final count", v, 0);
    rd(2'd0, v); check(v == 32'h2, "R9", "status after unit", v, 2);
    check(irqOut == 1'b1, "R9", "irq follows done", irqOut, 1);
  endtask

  initial begin
    logic [31:0] v;
    $urandom(1234);
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rd(2'd0, v); check(v == 0, "R1", "status", v, 0);
    check(!irqOut && !inReady && !memReq, "R1", "outputs idle", {irqOut, inReady, memReq}, 0);

    runUnit(32'h40, 12, 1, 70);

    // R2 start loads counters and clears done left from previous unit
    setup(32'h100, 16, 0, 60, 0);
    wr(2'd0, 32'h1);
    rd(2'd0, v); check(v == 32'h1, "R2", "status running", v, 1);
    rd(2'd1, v); check(v == 32'h100, "R2", "current address", v, 32'h100);
    rd(2'd2, v); check(v == 16, "R2", "current count", v, 16);
    rd(2'd3, v); check(v == 0, "R12", "size readback", v, 0);
    @(negedge clk); #1; streamOn = 1;
    waitIrq("R7");

    // R9 clear by write of one only
    wr(2'd0, 32'h0);
    check(irqOut == 1'b1, "R9", "write zero keeps done", irqOut, 1);
    wr(2'd0, 32'h2);
    rd(2'd0, v); check(v == 0, "R9", "status after clear", v, 0);
    check(irqOut == 1'b0, "R9", "irq cleared", irqOut, 0);

    // R4/R5 stall with memory frozen, 32-bit elements
    setup(32'h200, 20, 2, 100, 1);
    wr(2'd0, 32'h1);
    @(negedge clk); #1; streamOn = 1;
    repeat (40) @(negedge clk);
    rd(2'd2, v); check(v == 32'(20 - MAXOUT - 2), "R4", "stalled count 32-bit", v, 20 - MAXOUT - 2);
    check(inReady == 1'b0, "R4", "ready low when full", inReady, 0);
    check(reqCount - ackCount == MAXOUT, "R5", "in-flight at stall", reqCount - ackCount, MAXOUT);
    // R10 start mid-run is ignored
    wr(2'd1, 32'h300); wr(2'd2, 32'h5);
    wr(2'd0, 32'h1);
    rd(2'd1, v); check(v == 32'h200 + 8 * 4, "R10", "address after mid-run start", v, 32'h200 + 32);
    rd(2'd2, v); check(v == 12, "R10", "count after mid-run start", v, 12);
    @(negedge clk); #1; memStall = 0;
    waitIrq("R7");

    // R4 stall with 8-bit elements
    setup(32'h80, 20, 0, 100, 1);
    wr(2'd0, 32'h1);
    @(negedge clk); #1; streamOn = 1;
    repeat (40) @(negedge clk);
    rd(2'd2, v); check(v == 32'(20 - MAXOUT - 4), "R4", "stalled count 8-bit", v, 20 - MAXOUT - 4);
    rd(2'd1, v); check(v == 32'h80 + 10, "R4", "stalled address 8-bit", v, 32'h80 + 10);
    @(negedge clk); #1; memStall = 0;
    waitIrq("R7");

    // R11 zero-length unit
    setup(32'h10, 0, 1, 100, 0);
    wr(2'd0, 32'h1);
    @(negedge clk); #1; streamOn = 1;
    repeat (4) @(negedge clk);
    check(irqOut == 1'b1, "R11", "zero count done", irqOut, 1);
    check(reqCount == 0, "R11", "no memory writes", reqCount, 0);
    rd(2'd0, v); check(v == 32'h2, "R11", "status idle and done", v, 2);

    // random units
    for (int r = 0; r < 8; r++) begin
      int sz, n, base;
      sz = int'($urandom % 3);
      n = 1 + int'($urandom % 40);
      base = int'($urandom % 64) * 4;
      runUnit(base, n, sz, 30 + int'($urandom % 71));
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule